// File: doc/BRIEF.md
# PVT-Normalized Delay Tap Scaler

This block turns a delay programmed as a fraction of one clock period into a count of physical delay taps. A measurement input gives the number of taps that span one clock period. Each lane has an 8-bit fractional setting, where the period is divided into 512 steps, and a signed tap offset. Because the setting is a fraction of the period, the tap count it produces follows process, voltage and temperature as the measurement changes.

There are five lanes. Lanes 0 to 3 are the read strobe delays for data bytes 0 to 3. Lane 4 is the single write delay shared by the whole 32-bit bus. For each lane the block scales the setting by the measurement, adds the offset, and clamps the result to between zero and half a period. A result of zero means that only the fixed internal 12-tap delay is in effect. The usual offset of -12 cancels that fixed delay, so any scaled delay of 12 taps or less reports as zero. Only the write lane's total is also given on an 8-bit status output.

Results update only while the force-measure enable is high. When it is low, the last results are held.

Top module: `pvt_dly_scaler`

## Requirements
- R1: While `rst_n` is low at a clock edge, every lane output and the status output become 0 after that edge.
- R2: With `meas_en` high, lane k's output after the next edge is floor(meas × frac_k / 512) + off_k when that value lies between 0 and floor(meas / 2). The offset is 8-bit two's complement.
- R3: A lane whose sum is negative reports 0. This includes the case where the scaled delay does not exceed the cancelled fixed delay.
- R4: A lane whose sum exceeds floor(meas / 2) reports floor(meas / 2).
- R5: Lanes are independent. Lane k uses bits [8k+7:8k] of `frac_set` and `tap_off` and drives bits [10k+9:10k] of `lane_taps`. Lanes 0 to 3 are the read bytes and lane 4 is the write lane.
- R6: `wr_status` equals lane 4's output when that output is 255 or less, and 255 when it is higher.
- R7: While `meas_en` is low, all outputs hold their values whatever the data inputs do.
- R8: A change on the inputs with `meas_en` high shows on the outputs after exactly one rising edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_en | input | 1 | Force-measure enable; high lets results update |
| meas_taps | input | 10 | Taps in one clock period |
| frac_set | input | 40 | Per-lane fractional delay, 8 bits each, 512 steps per period |
| tap_off | input | 40 | Per-lane signed tap offset, 8 bits each |
| lane_taps | output | 50 | Per-lane clamped tap count, 10 bits each |
| wr_status | output | 8 | Write-lane total, saturated to 8 bits |

## Verification
Every result passes through one register, so it is due one rising edge after inputs are applied with the enable high. The bench drives inputs on the falling edge and samples 1 ns after the following rising edge. For the latency requirement it also samples between driving the inputs and that edge, where the old value must still be present. For the hold case it samples after three edges with the enable low.

// File: rtl/pvt_dly_pkg.sv
// Package: shared constants for the delay tap scaler.
// Assumes the period is divided into a power-of-two number of steps.
package pvt_dly_pkg;
    localparam int LANES_DEF  = 5;   // four read bytes plus one write lane
    localparam int STEP_LOG2  = 9;   // 512 fractional steps per period
endpackage

// File: rtl/pvt_dly_lane_map.sv
// Module: combinational scaler for one lane.
// Computes floor(meas*frac/2^STEP_LOG2) + off and clamps it to [0, meas/2].
// Assumes SUM_W is wide enough that the sum of scaled and offset never wraps.
module pvt_dly_lane_map #(
    parameter int MEAS_W = 10,
    parameter int FRAC_W = 8,
    parameter int OFF_W  = 8
) (
    input  logic [MEAS_W-1:0]        meas,
    input  logic [FRAC_W-1:0]        frac,
    input  logic signed [OFF_W-1:0]  off,
    output logic [MEAS_W-1:0]        taps
);
    localparam int PROD_W = MEAS_W + FRAC_W;
    localparam int SCL_W  = PROD_W - pvt_dly_pkg::STEP_LOG2;
    localparam int WIDE_W = (SCL_W > OFF_W) ? SCL_W : OFF_W;
    localparam int SUM_W  = ((WIDE_W > MEAS_W) ? WIDE_W : MEAS_W) + 2;

    logic [PROD_W-1:0]        prod;
    logic [SCL_W-1:0]         scaled;
    logic signed [SUM_W-1:0]  scl_s;
    logic signed [SUM_W-1:0]  off_s;
    logic signed [SUM_W-1:0]  sum;
    logic signed [SUM_W-1:0]  half_s;

    // Scale the fraction by the measured period and add the signed offset.
    always_comb begin
        prod   = PROD_W'(meas) * PROD_W'(frac);
        scaled = SCL_W'(prod >> pvt_dly_pkg::STEP_LOG2);
        scl_s  = SUM_W'(scaled);
        off_s  = SUM_W'(off);
        sum    = scl_s + off_s;
        half_s = SUM_W'(meas >> 1);
    end

    // Clamp the sum to the legal range of zero up to half a period.
    always_comb begin
        if (sum < 0)
            taps = '0;
        else if (sum > half_s)
            taps = meas >> 1;
        else
            taps = sum[MEAS_W-1:0];
    end
endmodule

// File: rtl/pvt_dly_stat_sat.sv
// Module: saturates a tap count to the width of the status field.
// Assumes STAT_W <= IN_W.
module pvt_dly_stat_sat #(
    parameter int IN_W   = 10,
    parameter int STAT_W = 8
) (
    input  logic [IN_W-1:0]   taps,
    output logic [STAT_W-1:0] stat
);
    localparam logic [IN_W-1:0] STAT_MAX = IN_W'((1 << STAT_W) - 1);

    // Pass the count through, or all ones when it does not fit.
    always_comb begin
        if (taps > STAT_MAX)
            stat = '1;
        else
            stat = STAT_W'(taps);
    end
endmodule

// File: rtl/pvt_dly_scaler.sv
// Module: top of the delay tap scaler.
// Builds one lane mapper per lane, registers all lane results and the
// write-lane status while meas_en is high, and holds them otherwise.
// Assumes the highest-numbered lane is the write lane.
module pvt_dly_scaler #(
    parameter int N_LANE = pvt_dly_pkg::LANES_DEF,
    parameter int MEAS_W = 10,
    parameter int FRAC_W = 8,
    parameter int OFF_W  = 8,
    parameter int STAT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       meas_en,
    input  logic [MEAS_W-1:0]          meas_taps,
    input  logic [N_LANE*FRAC_W-1:0]   frac_set,
    input  logic [N_LANE*OFF_W-1:0]    tap_off,
    output logic [N_LANE*MEAS_W-1:0]   lane_taps,
    output logic [STAT_W-1:0]          wr_status
);
    localparam int WR_IDX = N_LANE - 1;

    logic [MEAS_W-1:0] calc   [N_LANE];
    logic [MEAS_W-1:0] lane_q [N_LANE];
    logic [STAT_W-1:0] stat_d;
    logic [STAT_W-1:0] stat_q;

    for (genvar i = 0; i < N_LANE; i++) begin : g_lane
        logic signed [OFF_W-1:0] off_i;
        assign off_i = $signed(tap_off[i*OFF_W +: OFF_W]);

        pvt_dly_lane_map #(
            .MEAS_W (MEAS_W),
            .FRAC_W (FRAC_W),
            .OFF_W  (OFF_W)
        ) u_map (
            .meas (meas_taps),
            .frac (frac_set[i*FRAC_W +: FRAC_W]),
            .off  (off_i),
            .taps (calc[i])
        );

        // Capture this lane's result while measuring, hold it otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q[i] <= '0;
            else if (meas_en)
                lane_q[i] <= calc[i];
        end

        assign lane_taps[i*MEAS_W +: MEAS_W] = lane_q[i];

        // R4: a captured result never exceeds half the measured period.
        a_r4_half_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
            meas_en |=> (lane_q[i] <= ($past(meas_taps) >> 1)));

        // R3: a zero fraction with a non-positive offset floors at zero.
        a_r3_zero_floor: assert property (@(posedge clk) disable iff (!rst_n)
            (meas_en && frac_set[i*FRAC_W +: FRAC_W] == '0 && off_i <= 0)
            |=> (lane_q[i] == '0));

        // R7: with the enable low the lane result does not move.
        a_r7_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !meas_en |=> $stable(lane_q[i]));

        // R1: reset clears the lane.
        a_r1_lane_clear: assert property (@(posedge clk)
            !rst_n |=> (lane_q[i] == '0));
    end

    pvt_dly_stat_sat #(
        .IN_W   (MEAS_W),
        .STAT_W (STAT_W)
    ) u_sat (
        .taps (calc[WR_IDX]),
        .stat (stat_d)
    );

    // Capture the saturated write-lane total alongside the lanes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else if (meas_en)
            stat_q <= stat_d;
    end

    assign wr_status = stat_q;

    // R6: the status register tracks the write-lane register, saturated.
    a_r6_status_track: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_q[WR_IDX] > MEAS_W'((1 << STAT_W) - 1)) ? (stat_q == '1)
                                                      : (MEAS_W'(stat_q) == lane_q[WR_IDX]));

    // R7: with the enable low the status does not move.
    a_r7_stat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_en |=> $stable(stat_q));
endmodule

// File: tb/sim_pvt_dly_scaler.sv
module sim_pvt_dly_scaler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        meas_en = 1'b0;
    logic [9:0]  meas_taps = '0;
    logic [39:0] frac_set = '0;
    logic [39:0] tap_off = '0;
    logic [49:0] lane_taps;
    logic [7:0]  wr_status;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pvt_dly_scaler u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .meas_en   (meas_en),
        .meas_taps (meas_taps),
        .frac_set  (frac_set),
        .tap_off   (tap_off),
        .lane_taps (lane_taps),
        .wr_status (wr_status)
    );

    typedef struct packed {
        logic [9:0] m;
        logic [7:0] f;
        logic [7:0] o;
        logic [9:0] e;
    } vec_t;

    // meas, frac, offset (two's complement), expected lane result
    localparam vec_t VECS [10] = '{
        '{10'd144,  8'd128, 8'hF4, 10'd24 },   // R2 quarter period less 12
        '{10'd200,  8'd128, 8'hF4, 10'd38 },   // R2
        '{10'd144,  8'd40,  8'hF4, 10'd0  },   // R3 below fixed delay
        '{10'd144,  8'd48,  8'hF4, 10'd1  },   // R2 truncation
        '{10'd1000, 8'd200, 8'h00, 10'd390},   // R6 write lane saturates status
        '{10'd144,  8'd255, 8'd20, 10'd72 },   // R4 clamp at half
        '{10'd1000, 8'd255, 8'd100,10'd500},   // R4
        '{10'd511,  8'd0,   8'd127,10'd127},   // R2 offset only
        '{10'd300,  8'd100, 8'h80, 10'd0  },   // R3 most negative offset
        '{10'd144,  8'd255, 8'hF4, 10'd59 }    // R2 write lane
    };

    function automatic logic [9:0] lane_of(input int k);
        return lane_taps[k*10 +: 10];
    endfunction

    function automatic logic [7:0] sat8(input logic [9:0] v);
        return (v > 10'd255) ? 8'd255 : v[7:0];
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [9:0] held;
        logic [7:0] held_s;

        // R1: outputs clear under reset
        repeat (3) @(posedge clk);
        #1;
        for (int k = 0; k < 5; k++) check("R1 reset lane", lane_of(k), 0);
        check("R1 reset status", wr_status, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R6: table walk, one active lane per vector
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            meas_en   = 1'b1;
            meas_taps = VECS[i].m;
            frac_set  = '0;
            tap_off   = '0;
            frac_set[(i%5)*8 +: 8] = VECS[i].f;
            tap_off[(i%5)*8 +: 8]  = VECS[i].o;
            @(posedge clk);
            #1;
            for (int k = 0; k < 5; k++)
                check("R2/R5 lane value", lane_of(k), (k == i%5) ? int'(VECS[i].e) : 0);
            check("R6 status", wr_status, (i%5 == 4) ? int'(sat8(VECS[i].e)) : 0);
        end

        // R7: enable low, inputs change, outputs hold
        held   = lane_of(4);
        held_s = wr_status;
        @(negedge clk);
        meas_en   = 1'b0;
        meas_taps = 10'd512;
        frac_set  = '0;
        tap_off   = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R7 hold lane4", lane_of(4), held);
        check("R7 hold status", wr_status, held_s);

        // R8: change visible only after one edge
        @(negedge clk);
        meas_en = 1'b1;
        #1;
        check("R8 before edge", lane_of(4), held);
        @(posedge clk);
        #1;
        check("R8 after edge", lane_of(4), 0);
        check("R8 status after edge", wr_status, 0);

        // R5: all lanes at once, meas 512 so scaled value equals frac
        @(negedge clk);
        meas_taps = 10'd512;
        frac_set  = {8'd255, 8'd200, 8'd255, 8'd100, 8'd10};
        tap_off   = {8'd127, 8'd100, 8'hFF,  8'hF4,  8'd0};
        @(posedge clk);
        #1;
        check("R5 lane0", lane_of(0), 10);
        check("R5 lane1", lane_of(1), 88);
        check("R5 lane2", lane_of(2), 254);
        check("R5 lane3 R4 clamp", lane_of(3), 256);
        check("R5 lane4 R4 clamp", lane_of(4), 256);
        check("R6 status saturate", wr_status, 255);

        // R1: reset in mid-operation with enable high
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        for (int k = 0; k < 5; k++) check("R1 mid reset lane", lane_of(k), 0);
        check("R1 mid reset status", wr_status, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule